// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides whether a received frame addressed to a group (multicast) destination is accepted. The six destination-address bytes are presented one per cycle in the order they appear on the wire. A reflected CRC-32 is run over them, and nine bits of the result select one entry of a 512-entry, one-bit-per-entry acceptance table. One cycle after the sixth byte, a single-cycle decision pulse reports accept or reject.

The table is programmed one entry per write. Each write carries a 9-bit index and a set/clear flag. Software that wants every multicast frame writes all 512 indices with the flag set. A promiscuous input forces acceptance of every address, whatever the table holds. Unicast addresses, meaning those whose group bit is 0, are never accepted through the table.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset, `dec_valid` and `dec_accept` are 0 and every table entry is clear, so no multicast address is accepted until entries are set.
- R2: A byte with `in_valid` and `in_first` both high starts a new address. That byte and the five valid bytes after it are the six address bytes, in wire order. The CRC starts at 0xFFFFFFFF and processes each byte least significant bit first with the reflected polynomial 0xEDB88320. No final inversion is applied.
- R3: The table index is formed by bit-reversing the 32-bit CRC and taking bits 31 down to 23 of the result. Index bit 8 equals CRC bit 0, and index bit 0 equals CRC bit 8.
- R4: `dec_valid` is high for exactly one cycle, in the cycle after the sixth address byte is accepted. `dec_accept` is 0 whenever `dec_valid` is 0.
- R5: With `promisc` low, an address whose group bit (bit 0 of the first byte) is 1 is accepted exactly when the table entry at its index is set.
- R6: With `promisc` low, an address whose group bit is 0 is rejected, whatever the table holds.
- R7: When `promisc` is high in the cycle of the sixth byte, the decision is accept, for any address.
- R8: A table write (`tbl_wr` high) uses `tbl_wdata[8:0]` as the index. `tbl_wdata[9]`=1 sets the entry and 0 clears it. The change takes effect from the next cycle, so a lookup in the same cycle sees the old value.
- R9: Valid bytes that arrive after the sixth byte, and before the next `in_first`, are ignored and produce no decision.
- R10: Once all 512 indices have been written with the set flag, every group address is accepted and unicast addresses are still rejected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Address byte valid |
| in_first | input | 1 | Marks the first byte of a destination address |
| in_byte | input | 8 | Destination address byte, wire order |
| promisc | input | 1 | Accept every address |
| tbl_wr | input | 1 | Table write strobe |
| tbl_wdata | input | 10 | [8:0] entry index, [9] set (1) or clear (0) |
| dec_valid | output | 1 | Decision pulse |
| dec_accept | output | 1 | Accept flag, meaningful while dec_valid is high |

## Verification
A table write and a lookup can fall in the same cycle. This happens when the write strobe lands in the same cycle as the sixth address byte and targets that address's own index. The bench provokes this case twice. In the first, a set write meets an address whose entry is clear, and the decision must be reject; a repeat of the same address afterwards must be accepted. In the second, a clear write meets a set entry, and the decision must still be accept.

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
  parameter int          IDX_W      = 9,
  parameter int          ADDR_BYTES = 6,
  parameter logic [31:0] POLY       = 32'hEDB88320
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           in_first,
  input  logic [7:0]     in_byte,
  input  logic           promisc,
  input  logic           tbl_wr,
  input  logic [IDX_W:0] tbl_wdata,
  output logic           dec_valid,
  output logic           dec_accept
);
  localparam int TBL   = 1 << IDX_W;
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES - 1);
  localparam logic [CNT_W-1:0] DONE = CNT_W'(ADDR_BYTES);

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++)
      r = r[0] ? ((r >> 1) ^ POLY) : (r >> 1);
    return r;
  endfunction

  logic [TBL-1:0]   tbl_q;
  logic [31:0]      crc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             grp_q;

  logic [CNT_W-1:0] cnt_cur;
  logic [31:0]      crc_nx;
  logic [IDX_W-1:0] idx;
  logic             take, last, grp_cur;

  assign cnt_cur = in_first ? '0 : cnt_q;
  assign take    = in_valid && (cnt_cur != DONE);
  assign last    = take && (cnt_cur == LAST);
  assign crc_nx  = crc_byte(in_first ? 32'hFFFFFFFF : crc_q, in_byte);
  assign grp_cur = in_first ? in_byte[0] : grp_q;

  for (genvar i = 0; i < IDX_W; i++) begin : g_idx
    assign idx[i] = crc_nx[IDX_W-1-i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl_q      <= '0;
      crc_q      <= 32'hFFFFFFFF;
      cnt_q      <= '0;
      grp_q      <= 1'b0;
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      if (tbl_wr) tbl_q[tbl_wdata[IDX_W-1:0]] <= tbl_wdata[IDX_W];
      if (take) begin
        crc_q <= crc_nx;
        cnt_q <= cnt_cur + 1'b1;
        grp_q <= grp_cur;
      end
      dec_valid  <= last;
      dec_accept <= last && (promisc || (grp_cur && tbl_q[idx]));
    end
  end

  // R4: decision is a one-cycle pulse, accept never outside it
  p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);
  p_accept_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_accept |-> dec_valid);
  // R7: promiscuous forces accept
  p_promisc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (last && promisc) |=> (dec_valid && dec_accept));
  // R6: unicast never passes through the table
  p_unicast_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !promisc && !grp_cur) |=> (dec_valid && !dec_accept));
  // R9: byte counter never passes the address length
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= DONE);
endmodule

// File: tb/mcast_hash_filter_test.sv
module mcast_hash_filter_test;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_first = 0, promisc = 0, tbl_wr = 0;
  logic [7:0] in_byte = 0;
  logic [9:0] tbl_wdata = 0;
  logic dec_valid, dec_accept;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  mcast_hash_filter uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_byte(in_byte), .promisc(promisc), .tbl_wr(tbl_wr), .tbl_wdata(tbl_wdata),
    .dec_valid(dec_valid), .dec_accept(dec_accept));

  // {address, program own index, promisc, expected accept}
  localparam logic [50:0] VEC [8] = '{
    {48'h01005E000001, 1'b1, 1'b0, 1'b1},
    {48'h01005E7FFFFA, 1'b0, 1'b0, 1'b0},
    {48'h333300000001, 1'b1, 1'b0, 1'b1},
    {48'h0180C2000000, 1'b0, 1'b1, 1'b1},
    {48'h001122334455, 1'b1, 1'b0, 1'b0},
    {48'h02AABBCCDDEE, 1'b0, 1'b1, 1'b1},
    {48'hFFFFFFFFFFFF, 1'b1, 1'b0, 1'b1},
    {48'h01005E0A0B0C, 1'b0, 1'b0, 1'b0}
  };

  function automatic logic [8:0] hidx(input logic [47:0] a);
    logic [31:0] c = 32'hFFFFFFFF;
    logic [8:0] r;
    for (int b = 5; b >= 0; b--) begin
      c ^= {24'd0, a[b*8 +: 8]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    for (int i = 0; i < 9; i++) r[i] = c[8-i];
    return r;
  endfunction

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual valid/accept=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic twrite(input logic [8:0] i, input logic s);
    @(negedge clk); tbl_wr = 1; tbl_wdata = {s, i};
    @(negedge clk); tbl_wr = 0;
  endtask

  // sends an address; optional table write on the sixth byte; returns outputs after it
  task automatic send(input logic [47:0] a, input logic pr, input logic wr6,
                      input logic [9:0] wd, output logic [1:0] res);
    for (int b = 5; b >= 0; b--) begin
      @(negedge clk);
      in_valid = 1; in_first = (b == 5); in_byte = a[b*8 +: 8];
      promisc = pr; tbl_wr = wr6 && (b == 0); tbl_wdata = wd;
    end
    @(negedge clk);
    in_valid = 0; in_first = 0; tbl_wr = 0; promisc = 0;
    res = {dec_valid, dec_accept};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0] r;
    logic [47:0] a;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {dec_valid, dec_accept}, 2'b00);
    rst_n = 1;
    send(48'h01005E000001, 0, 0, 0, r);
    chk("R1 empty table rejects", r, 2'b10);
    @(negedge clk);
    chk("R4 pulse one cycle", {dec_valid, dec_accept}, 2'b00);

    for (int v = 0; v < 8; v++) begin
      a = VEC[v][50:3];
      if (VEC[v][2]) twrite(hidx(a), 1);
      send(a, VEC[v][1], 0, 0, r);
      chk("R2 R3 R5 R6 R7 vector", r, {1'b1, VEC[v][0]});
      if (VEC[v][2]) twrite(hidx(a), 0);
    end

    a = 48'h01005E112233;
    twrite(hidx(a) ^ 9'h001, 1);
    send(a, 0, 0, 0, r);
    chk("R3 neighbour index rejects", r, 2'b10);
    twrite(hidx(a) ^ 9'h001, 0);
    twrite(hidx(a), 1);
    send(a, 0, 0, 0, r);
    chk("R5 own index accepts", r, 2'b11);
    twrite(hidx(a), 0);
    send(a, 0, 0, 0, r);
    chk("R8 clear takes effect", r, 2'b10);

    send(a, 0, 1, {1'b1, hidx(a)}, r);
    chk("R8 same-cycle set sees old", r, 2'b10);
    send(a, 0, 0, 0, r);
    chk("R8 set visible afterwards", r, 2'b11);
    send(a, 0, 1, {1'b0, hidx(a)}, r);
    chk("R8 same-cycle clear sees old", r, 2'b11);
    send(a, 0, 0, 0, r);
    chk("R8 clear visible afterwards", r, 2'b10);

    twrite(hidx(a), 1);
    send(a, 0, 0, 0, r);
    for (int t = 0; t < 8; t++) begin
      @(negedge clk); in_valid = 1; in_byte = 8'h5A + t[7:0];
      chk("R9 trailing byte ignored", {dec_valid, dec_accept}, (t == 0) ? 2'b00 : 2'b00);
    end
    @(negedge clk); in_valid = 0;
    chk("R9 no decision after trailing", {dec_valid, dec_accept}, 2'b00);
    twrite(hidx(a), 0);

    for (int i = 0; i < 512; i++) twrite(i[8:0], 1);
    for (int n = 0; n < 6; n++) begin
      a = {8'h01 | (8'h22 * n[7:0]), 8'h5E, 8'h3C * n[7:0], 8'h77, 8'hA5 ^ n[7:0], n[7:0]};
      send(a, 0, 0, 0, r);
      chk("R10 all multicast accepted", r, 2'b11);
    end
    send(48'h00AABBCCDDEE, 0, 0, 0, r);
    chk("R10 R6 unicast still rejected", r, 2'b10);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule